// File: doc/BRIEF.md
# Supply-Qualified Reset Release Sequencer

This block produces the active-low reset for a microcontroller from digitized supply-monitor flags. It keeps reset asserted while the regulated output is below its reset threshold. Once the supply is good it waits a fixed release delay before letting reset go high. The delay is counted in ticks of an external millisecond-based timebase, and a two-bit strap selects its length. While the processor runs, a dip on the output rail or a low input rail asserts reset again, but only if the fault lasts longer than a short reaction filter. A fault request from a neighbouring watchdog also asserts reset and restarts the full release delay.

The comparators, thresholds and the analog output stage sit outside the block. The pin is modelled as a logic level and an output enable. When the supply-present flag is low, the enable is dropped so the pin floats. Each time reset is released the block emits a one-cycle strobe, so a downstream watchdog can begin its sequence. All inputs and outputs are plain control and status levels, with no streaming handshake.

Top module: `por_release_seq`

## Requirements
- R1: After a core reset (`rst` high for at least one edge), `rst_n_o` is 0. While `supply_ok_i` is 1 and `vout_ok_i` is 0, `rst_n_o` stays 0 for any number of timebase ticks.
- R2: With `strap_i` = 2'b00 (fast), `rst_n_o` rises on the clock edge that accepts the FAST_MS*TICKS_PER_MS-th `tick_i` pulse counted after the supply became good. It is still 0 after one tick fewer.
- R3: With `strap_i` equal to 2'b01, 2'b10 or 2'b11 (slow), the release needs SLOW_MS*TICKS_PER_MS ticks, with the same edge rule as R2.
- R4: While released, a low on `vout_ok_i` lasting at most GLITCH_CYCLES clock cycles leaves `rst_n_o` at 1. A low lasting GLITCH_CYCLES+1 cycles drives `rst_n_o` to 0 on the edge after that last low cycle.
- R5: While released, `vin_low_i` high is filtered the same way as R4 and asserts reset when it lasts more than GLITCH_CYCLES cycles.
- R6: `rst_oe_o` equals `supply_ok_i`. While `supply_ok_i` is 0, reset is held and no release happens regardless of ticks.
- R7: A one-cycle `wdt_fault_i` pulse while released makes `rst_n_o` 0 on the next edge. The full release delay then restarts from zero.
- R8: `rel_pulse_o` is 1 for exactly one cycle, the first cycle in which `rst_n_o` is 1 after being 0.
- R9: A core reset during a partly elapsed delay clears the count, so a full delay is needed afterwards.
- R10: Any supply fault during the delay (unfiltered) returns the block to holding and restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high core reset |
| tick_i | input | 1 | One-cycle timebase pulse, TICKS_PER_MS per millisecond |
| supply_ok_i | input | 1 | Output rail high enough for the reset driver to work |
| vout_ok_i | input | 1 | Output rail above reset threshold |
| vin_low_i | input | 1 | Input rail below its own threshold |
| strap_i | input | 2 | Reset timing strap: 00 fast, others slow |
| wdt_fault_i | input | 1 | Watchdog fault request pulse |
| rst_n_o | output | 1 | Reset level, 0 = asserted |
| rst_oe_o | output | 1 | Pin driver enable, 0 = high impedance |
| rel_pulse_o | output | 1 | One-cycle strobe on reset release |

## Verification
A wrong delay count would show at `rst_n_o` as a release one or more ticks early or late. The bench compares the edge against the exact tick index for every strap value. A glitch filter that is off by one would show as reset firing on a dip of exactly GLITCH_CYCLES cycles, or missing one of GLITCH_CYCLES+1. The sweep over dip lengths sees either within two cycles of the dip's end. A state machine stuck in holding or running shows up when the next release check is reached, because the strobe and the reset level disagree with the computed tick count.

// File: rtl/por_release_pkg.sv
package por_release_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } por_state_e;

  localparam logic [1:0] STRAP_FAST = 2'b00;
endpackage

// File: rtl/por_fault_filter.sv
module por_fault_filter #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic qual_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !raw_i) cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = raw_i && (cnt_q == LIM);

  AST_QUAL_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    qual_o |-> $past(raw_i)) else $error("qualified fault without prior raw fault"); // R4
endmodule

// File: rtl/por_delay_timer.sv
module por_delay_timer #(
  parameter int TICKS_PER_MS = 8,
  parameter int FAST_MS      = 16,
  parameter int SLOW_MS      = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic tick_i,
  input  logic slow_i,
  output logic done_o
);
  localparam int FAST_T = FAST_MS * TICKS_PER_MS;
  localparam int SLOW_T = SLOW_MS * TICKS_PER_MS;
  localparam int MAX_T  = (SLOW_T > FAST_T) ? SLOW_T : FAST_T;
  localparam int CW     = $clog2(MAX_T + 1);
  localparam logic [CW-1:0] FAST_LAST = CW'(FAST_T - 1);
  localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_T - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = slow_i ? SLOW_LAST : FAST_LAST;
  assign done_o = run_i && tick_i && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (cnt_q <= last)) else $error("delay count past target"); // R3
endmodule

// File: rtl/por_release_seq.sv
module por_release_seq
  import por_release_pkg::*;
#(
  parameter int TICKS_PER_MS  = 8,
  parameter int FAST_MS       = 16,
  parameter int SLOW_MS       = 32,
  parameter int GLITCH_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       supply_ok_i,
  input  logic       vout_ok_i,
  input  logic       vin_low_i,
  input  logic [1:0] strap_i,
  input  logic       wdt_fault_i,
  output logic       rst_n_o,
  output logic       rst_oe_o,
  output logic       rel_pulse_o
);
  por_state_e state_q, state_d;
  logic raw_fault, qual_fault, delay_done, rel_q, slow;

  assign raw_fault = !supply_ok_i || !vout_ok_i || vin_low_i;
  assign slow      = (strap_i != STRAP_FAST);

  por_fault_filter #(.LIMIT(GLITCH_CYCLES)) u_filt (
    .clk(clk), .rst(rst), .raw_i(raw_fault), .qual_o(qual_fault)
  );

  por_delay_timer #(
    .TICKS_PER_MS(TICKS_PER_MS), .FAST_MS(FAST_MS), .SLOW_MS(SLOW_MS)
  ) u_tmr (
    .clk(clk), .rst(rst), .run_i(state_q == ST_DELAY), .tick_i(tick_i),
    .slow_i(slow), .done_o(delay_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HOLD:  if (!raw_fault) state_d = ST_DELAY;
      ST_DELAY: if (raw_fault) state_d = ST_HOLD;
                else if (delay_done) state_d = ST_RUN;
      ST_RUN:   if (qual_fault || wdt_fault_i || !supply_ok_i) state_d = ST_HOLD;
      default:  state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HOLD;
      rel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rel_q   <= (state_d == ST_RUN) && (state_q != ST_RUN);
    end
  end

  assign rst_n_o     = (state_q == ST_RUN);
  assign rst_oe_o    = supply_ok_i;
  assign rel_pulse_o = rel_q;

  AST_HOLD_NO_JUMP: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD) |=> !rst_n_o) else $error("released straight from hold"); // R1
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> $past(tick_i)) else $error("release without a tick"); // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rel_pulse_o |=> !rel_pulse_o) else $error("strobe longer than a cycle"); // R8
  AST_STROBE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    rel_pulse_o == $rose(rst_n_o)) else $error("strobe not aligned to release"); // R8
  AST_WDT_FORCES: assert property (@(posedge clk) disable iff (rst)
    (rst_n_o && wdt_fault_i) |=> !rst_n_o) else $error("watchdog fault ignored"); // R7
  AST_NO_SUPPLY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |=> !rst_n_o) else $error("released without supply"); // R6
endmodule

// File: tb/sim_por_release_seq.sv
module sim_por_release_seq;
  localparam int TPM = 2, FMS = 16, SMS = 32, GL = 4;
  localparam int FAST_T = FMS * TPM;
  localparam int SLOW_T = SMS * TPM;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, sup = 1'b0, vok = 1'b0, vlow = 1'b0, wdt = 1'b0;
  logic [1:0] strap = 2'b00;
  logic rst_n, oe, rel;
  int checks = 0, errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  por_release_seq #(.TICKS_PER_MS(TPM), .FAST_MS(FMS), .SLOW_MS(SMS),
                    .GLITCH_CYCLES(GL)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick), .supply_ok_i(sup), .vout_ok_i(vok),
    .vin_low_i(vlow), .strap_i(strap), .wdt_fault_i(wdt),
    .rst_n_o(rst_n), .rst_oe_o(oe), .rel_pulse_o(rel)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  // supply made good, count full delay, verify exact release edge and strobe
  task automatic release_seq(input string req, input int target);
    sup = 1'b1; vok = 1'b1; vlow = 1'b0;
    step(2);
    ticks(target - 1);
    chk(req, rst_n, 1'b0);
    tick = 1'b1; @(negedge clk);
    tick = 1'b0;
    chk(req, rst_n, 1'b1);
    chk("R8", rel, 1'b1);
    @(negedge clk);
    chk("R8", rel, 1'b0);
    chk(req, rst_n, 1'b1);
  endtask

  always @(posedge clk) cyc++;

  initial begin
    while (cyc < 150000 && !done) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1", rst_n, 1'b0);
    chk("R8", rel, 1'b0);
    rst = 1'b0;
    // R1: output below threshold, ticks do not release
    sup = 1'b1; vok = 1'b0;
    ticks(SLOW_T + 4);
    chk("R1", rst_n, 1'b0);
    chk("R6", oe, 1'b1);

    // R2/R3: sweep every strap value
    for (int m = 0; m < 4; m++) begin
      strap = 2'(m);
      release_seq(m == 0 ? "R2" : "R3", m == 0 ? FAST_T : SLOW_T);
      vok = 1'b0; step(GL + 3);
      chk("R4", rst_n, 1'b0);
    end

    // R4: dip length sweep
    strap = 2'b00;
    for (int len = 1; len <= GL + 2; len++) begin
      release_seq("R2", FAST_T);
      vok = 1'b0; step(len);
      vok = 1'b1; step(2);
      chk("R4", rst_n, (len <= GL) ? 1'b1 : 1'b0);
      if (len <= GL) begin
        vok = 1'b0; step(GL + 2); vok = 1'b1;
      end
    end

    // R5: input-rail low, at and past filter limit
    release_seq("R2", FAST_T);
    vlow = 1'b1; step(GL); vlow = 1'b0; step(2);
    chk("R5", rst_n, 1'b1);
    vlow = 1'b1; step(GL + 1); vlow = 1'b0; step(2);
    chk("R5", rst_n, 1'b0);

    // R7: watchdog fault, then full delay again
    release_seq("R2", FAST_T);
    wdt = 1'b1; @(negedge clk); wdt = 1'b0;
    chk("R7", rst_n, 1'b0);
    release_seq("R7", FAST_T);

    // R10: fault during delay restarts count
    vok = 1'b0; step(GL + 2); vok = 1'b1; step(2);
    ticks(FAST_T - 3);
    vok = 1'b0; @(negedge clk); vok = 1'b1;
    release_seq("R10", FAST_T);

    // R9: core reset mid-delay
    vok = 1'b0; step(GL + 2); vok = 1'b1; step(2);
    ticks(FAST_T - 2);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R9", rst_n, 1'b0);
    release_seq("R9", FAST_T);

    // R6: supply absent -> high-Z and held
    sup = 1'b0; @(negedge clk);
    chk("R6", oe, 1'b0);
    chk("R6", rst_n, 1'b0);
    ticks(SLOW_T + 2);
    chk("R6", rst_n, 1'b0);
    chk("R6", oe, 1'b0);
    release_seq("R6", FAST_T);
    chk("R6", oe, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule